// File: doc/BRIEF.md
# Fine-Resolution Gate Pulse Generator

This block produces the high-side and low-side gate drive patterns for one synchronous buck switching channel, working from a digital on-time command. All edges are placed on a sub-clock grid of sixteen ticks per clock period. Each output is a 16-bit word per clock. Bit k of the word is the gate level during tick k of that clock period, with bit 0 the earliest tick. A downstream serializer turns these words into pins. The high-side on-time is limited between two programmed bounds. Two programmed gaps keep the switches apart: one from high-side off to low-side on, and one from low-side off to the next high-side on.

Two operating styles are available. In free-running style, switching periods follow each other back to back, with a programmed length in whole clocks. In one-shot style, each accepted trigger runs one high-side pulse, then one low-side pulse of programmed width. Both gates then stay low, so no reverse current can build up, until the next trigger arrives while the channel is idle. All settings are captured when a cycle starts and stay fixed until it ends.

Top module: `dpwm_fine`

## Requirements
- R1: While `rst` is high, and at every clock edge where `en` is low, both output words become all zeros. Dropping `en` aborts a cycle in progress. A later rise of `en` starts a new cycle from tick 0.
- R2: The cycle decision is made at a rising edge. The word for clock 0 of that cycle is presented after the next rising edge, and one word follows per clock. Bit k of a word stands for fine tick k, with bit 0 the earliest. Cycle tick t maps to word t/16, bit t%16.
- R3: The high-side on-time, in ticks, is ton = min(max(duty_cmd, ton_min), ton_max). The upper 8 bits of each 12-bit time field count clocks and the lower 4 bits count ticks. The high-side gate is high for cycle ticks [0, ton).
- R4: In free-running style (`mode_shot`=0), a cycle lasts period_clk clocks, and a value of 0 counts as 1. Let P be that length in ticks (clocks × 16). The low-side gate is high for ticks [ton+dead_hl, P−dead_lh), and is empty when that range is empty. The next cycle follows with no gap.
- R5: In one-shot style (`mode_shot`=1), a trigger sampled high while idle starts a cycle. The low side is high for ticks [ton+dead_hl, ton+dead_hl+ls_width). The cycle lasts ceil((ton+dead_hl+ls_width)/16) clocks, with a minimum of 1. After that, both gates stay low.
- R6: A trigger sampled during any clock of a running cycle, including its last clock, is ignored and does not restart or extend the cycle.
- R7: The time fields, `period_clk` and `mode_shot` are captured only at the edge that starts a cycle. Changes made mid-cycle affect only later cycles. A switch from free-running to one-shot style lets the running cycle finish and then waits for a trigger.
- R8: The two gate words never have the same bit high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low forces both gates low |
| mode_shot | input | 1 | 0 = free-running periods, 1 = one cycle per trigger |
| trig | input | 1 | Start request in one-shot style |
| duty_cmd | input | 12 | Commanded high-side on-time (8-bit clocks, 4-bit ticks) |
| ton_min | input | 12 | Lower limit on the high-side on-time |
| ton_max | input | 12 | Upper limit on the high-side on-time |
| dead_hl | input | 12 | Gap from high-side off to low-side on |
| dead_lh | input | 12 | Gap from low-side off to the period end (free-running) |
| ls_width | input | 12 | Low-side on-time in one-shot style |
| period_clk | input | 8 | Free-running period length in clocks |
| hs_ticks | output | 16 | High-side gate level per tick of the current clock |
| ls_ticks | output | 16 | Low-side gate level per tick of the current clock |

## Verification
Two pairs of events can fall on the same clock edge. The first is the last clock of a cycle together with a new trigger. The second is the last clock of a cycle together with new settings or a style change. The bench provokes the first by pulsing `trig` exactly on the final clock of a one-shot cycle, and by holding it high throughout. It provokes the second by changing durations at clock counts that are not multiples of the period. A behavioural model rebuilds each whole cycle as a queue of tick words, captured only when the model itself decides a cycle starts. Every output word is compared against that queue. This shows whether the trigger was dropped and whether the old or the new settings shaped each cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {
    RUN_FREE = 1'b0,
    RUN_SHOT = 1'b1
  } run_mode_e;
endpackage

// File: rtl/dpwm_cfg.sv
// Clamps the on-time and captures the cycle's tick boundaries and length at load.
module dpwm_cfg
  import dpwm_pkg::*;
#(
  parameter int CW = 8,
  parameter int FB = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 mode_shot,
  input  logic [CW+FB-1:0]     duty,
  input  logic [CW+FB-1:0]     tmin,
  input  logic [CW+FB-1:0]     tmax,
  input  logic [CW+FB-1:0]     dhl,
  input  logic [CW+FB-1:0]     dlh,
  input  logic [CW+FB-1:0]     lsw,
  input  logic [CW-1:0]        per,
  output logic [CW+FB+1:0]     hs_hi,
  output logic [CW+FB+1:0]     ls_lo,
  output logic [CW+FB+1:0]     ls_hi,
  output logic [CW+1:0]        len
);
  localparam int W    = CW + FB;
  localparam int EW   = W + 2;
  localparam int LW   = EW - FB;
  localparam int FINE = 1 << FB;

  run_mode_e       mode_c;
  logic [W-1:0]    t_floor, ton_c;
  logic [LW-1:0]   per_l, shot_len, len_c;
  logic [EW-1:0]   p_ticks, lo_c, free_hi, shot_hi, rnd, hi_c;

  always_comb begin
    mode_c   = run_mode_e'(mode_shot);
    t_floor  = (duty < tmin) ? tmin : duty;
    ton_c    = (t_floor > tmax) ? tmax : t_floor;
    per_l    = (per == '0) ? LW'(1) : LW'(per);
    p_ticks  = {per_l, {FB{1'b0}}};
    lo_c     = EW'(ton_c) + EW'(dhl);
    free_hi  = (EW'(dlh) >= p_ticks) ? '0 : (p_ticks - EW'(dlh));
    shot_hi  = lo_c + EW'(lsw);
    rnd      = shot_hi + EW'(FINE - 1);
    shot_len = (rnd[EW-1:FB] == '0) ? LW'(1) : rnd[EW-1:FB];
    if (mode_c == RUN_SHOT) begin
      hi_c  = shot_hi;
      len_c = shot_len;
    end else begin
      hi_c  = free_hi;
      len_c = per_l;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_hi <= '0;
      ls_lo <= '0;
      ls_hi <= '0;
      len   <= LW'(1);
    end else if (load) begin
      hs_hi <= EW'(ton_c);
      ls_lo <= lo_c;
      ls_hi <= hi_c;
      len   <= len_c;
    end
  end

  AST_CLAMP_MAX: assert property (@(posedge clk) disable iff (rst)
    load |=> (hs_hi <= EW'($past(tmax)))); // R3
  AST_CLAMP_MIN: assert property (@(posedge clk) disable iff (rst)
    (load && (tmin <= tmax)) |=> (hs_hi >= EW'($past(tmin)))); // R3
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |=> (len != '0)); // R5
endmodule

// File: rtl/dpwm_seq.sv
// Cycle sequencer: decides starts and counts clocks within a cycle.
module dpwm_seq #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          mode_shot,
  input  logic          trig,
  input  logic [LW-1:0] len,
  output logic          active,
  output logic [LW-1:0] cnt,
  output logic          last,
  output logic          start
);
  always_comb begin
    last  = active && (cnt == (len - LW'(1)));
    start = en && (mode_shot ? (trig && !active) : (!active || last));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (last) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt    <= cnt + LW'(1);
    end
  end

  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (en && active && !last && trig) |=> (active && (cnt != '0))); // R6
  AST_SHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (en && last && mode_shot) |=> !active); // R5
endmodule

// File: rtl/dpwm_span.sv
// Marks which fine ticks of the current clock fall inside [lo, hi).
module dpwm_span #(
  parameter int FB = 4,
  parameter int EW = 14
) (
  input  logic [EW-FB-1:0]     cnt,
  input  logic [EW-1:0]        lo,
  input  logic [EW-1:0]        hi,
  output logic [(1<<FB)-1:0]   bits
);
  localparam int FINE = 1 << FB;

  logic [EW-1:0] base;
  assign base = {cnt, {FB{1'b0}}};

  for (genvar k = 0; k < FINE; k++) begin : g_tick
    logic [EW-1:0] t;
    assign t       = base + EW'(k);
    assign bits[k] = (t >= lo) && (t < hi);
  end
endmodule

// File: rtl/dpwm_fine.sv
// Top: fine-resolution high/low gate word generator for one buck channel.
module dpwm_fine
  import dpwm_pkg::*;
#(
  parameter int CW = 8,
  parameter int FB = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  mode_shot,
  input  logic                  trig,
  input  logic [CW+FB-1:0]      duty_cmd,
  input  logic [CW+FB-1:0]      ton_min,
  input  logic [CW+FB-1:0]      ton_max,
  input  logic [CW+FB-1:0]      dead_hl,
  input  logic [CW+FB-1:0]      dead_lh,
  input  logic [CW+FB-1:0]      ls_width,
  input  logic [CW-1:0]         period_clk,
  output logic [(1<<FB)-1:0]    hs_ticks,
  output logic [(1<<FB)-1:0]    ls_ticks
);
  localparam int W    = CW + FB;
  localparam int EW   = W + 2;
  localparam int LW   = EW - FB;
  localparam int FINE = 1 << FB;

  logic [EW-1:0]   hs_hi, ls_lo, ls_hi;
  logic [LW-1:0]   len, cnt;
  logic            active, last, start;
  logic [FINE-1:0] hs_w, ls_w;

  dpwm_cfg #(.CW(CW), .FB(FB)) u_cfg (
    .clk(clk), .rst(rst), .load(start), .mode_shot(mode_shot),
    .duty(duty_cmd), .tmin(ton_min), .tmax(ton_max),
    .dhl(dead_hl), .dlh(dead_lh), .lsw(ls_width), .per(period_clk),
    .hs_hi(hs_hi), .ls_lo(ls_lo), .ls_hi(ls_hi), .len(len)
  );

  dpwm_seq #(.LW(LW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .mode_shot(mode_shot), .trig(trig),
    .len(len), .active(active), .cnt(cnt), .last(last), .start(start)
  );

  dpwm_span #(.FB(FB), .EW(EW)) u_hs (
    .cnt(cnt), .lo('0), .hi(hs_hi), .bits(hs_w)
  );

  dpwm_span #(.FB(FB), .EW(EW)) u_ls (
    .cnt(cnt), .lo(ls_lo), .hi(ls_hi), .bits(ls_w)
  );

  always_ff @(posedge clk) begin
    if (rst || !en || !active) begin
      hs_ticks <= '0;
      ls_ticks <= '0;
    end else begin
      hs_ticks <= hs_w;
      ls_ticks <= ls_w;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    ((hs_ticks & ls_ticks) == '0)); // R8
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((hs_ticks == '0) && (ls_ticks == '0))); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (en && active && !last) |=> ($stable(hs_hi) && $stable(ls_lo) && $stable(ls_hi) && $stable(len))); // R7
endmodule

// File: tb/sim_dpwm_fine.sv
module sim_dpwm_fine;
  logic        clk = 1'b0;
  logic        rst, en, mode_shot, trig;
  logic [11:0] duty_cmd, ton_min, ton_max, dead_hl, dead_lh, ls_width;
  logic [7:0]  period_clk;
  logic [15:0] hs_ticks, ls_ticks;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] hq[$];
  logic [15:0] lq[$];
  logic [15:0] exp_h, exp_l;

  always #5 clk = ~clk;

  dpwm_fine u0 (
    .clk(clk), .rst(rst), .en(en), .mode_shot(mode_shot), .trig(trig),
    .duty_cmd(duty_cmd), .ton_min(ton_min), .ton_max(ton_max),
    .dead_hl(dead_hl), .dead_lh(dead_lh), .ls_width(ls_width),
    .period_clk(period_clk), .hs_ticks(hs_ticks), .ls_ticks(ls_ticks)
  );

  // Build a whole cycle as per-clock tick words from the requirement formulas.
  task automatic build_cycle();
    int ton, a, b, nclk, p;
    ton = duty_cmd;
    if (ton < ton_min) ton = ton_min;
    if (ton > ton_max) ton = ton_max;
    a = ton + dead_hl;
    if (mode_shot) begin
      b = a + ls_width;
      nclk = (b + 15) / 16;
      if (nclk == 0) nclk = 1;
    end else begin
      p = (period_clk == 0) ? 1 : period_clk;
      nclk = p;
      b = p * 16 - dead_lh;
    end
    for (int c = 0; c < nclk; c++) begin
      logic [15:0] h, l;
      for (int k = 0; k < 16; k++) begin
        int t;
        t = c * 16 + k;
        h[k] = (t < ton);
        l[k] = (t >= a) && (t < b);
      end
      hq.push_back(h);
      lq.push_back(l);
    end
  endtask

  task automatic step(input string tag);
    bit idle;
    if (rst || !en) begin
      exp_h = '0; exp_l = '0;
      hq.delete(); lq.delete();
    end else begin
      idle = (hq.size() == 0);
      if (!idle) begin
        exp_h = hq.pop_front();
        exp_l = lq.pop_front();
      end else begin
        exp_h = '0; exp_l = '0;
      end
      if (mode_shot ? (trig && idle) : (hq.size() == 0)) build_cycle();
    end
    @(posedge clk);
    #1;
    n_tests++;
    if (hs_ticks !== exp_h || ls_ticks !== exp_l) begin
      n_fail++;
      $display("FAIL %s: hs=%h exp %h, ls=%h exp %h", tag, hs_ticks, exp_h, ls_ticks, exp_l);
    end
    n_tests++;
    if ((hs_ticks & ls_ticks) !== 16'h0) begin
      n_fail++;
      $display("FAIL R8: overlap hs=%h ls=%h exp no common bit", hs_ticks, ls_ticks);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    rst = 1'b1; en = 1'b1; mode_shot = 1'b0; trig = 1'b0;
    duty_cmd = 12'h025; ton_min = 12'h010; ton_max = 12'h040;
    dead_hl = 12'd5; dead_lh = 12'd7; ls_width = 12'h01b; period_clk = 8'd6;
    #2;
    run(3, "R1 reset");
    rst = 1'b0;
    run(20, "R2/R4 free run");
    duty_cmd = 12'h003;
    run(14, "R3 clamp low");
    duty_cmd = 12'h0ff;
    run(14, "R3 clamp high");
    duty_cmd = 12'h022;
    run(3, "R7 mid change");
    dead_hl = 12'd20;
    run(2, "R7 mid change");
    period_clk = 8'd4;
    run(12, "R7 mid change");
    period_clk = 8'd2; ton_max = 12'h040; duty_cmd = 12'h030;
    run(8, "R4 on-time past period");
    period_clk = 8'd0; duty_cmd = 12'h008; dead_hl = 12'd2; dead_lh = 12'd3;
    run(6, "R4 zero period");
    period_clk = 8'd3; dead_lh = 12'd60;
    run(8, "R4 low side empty");
    dead_lh = 12'd7; period_clk = 8'd5; duty_cmd = 12'h020;
    run(7, "R1 running");
    en = 1'b0;
    run(3, "R1 disabled");
    en = 1'b1;
    run(8, "R1 re-enable");
    // style change: running cycle finishes, then waits
    mode_shot = 1'b1; duty_cmd = 12'h022; dead_hl = 12'd3; ls_width = 12'h01b;
    run(8, "R7 style switch");
    trig = 1'b1;
    step("R5 trigger");
    trig = 1'b0;
    run(2, "R5 one-shot");
    trig = 1'b1;
    step("R6 trigger while busy");
    trig = 1'b0;
    run(6, "R5 one-shot end");
    // trigger exactly on the final clock (cycle is 4 clocks: 34+3+27=64 ticks)
    trig = 1'b1;
    step("R5 trigger");
    trig = 1'b0;
    run(3, "R5 one-shot");
    trig = 1'b1;
    step("R6 trigger on last clock");
    trig = 1'b0;
    run(6, "R6 after ignored trigger");
    trig = 1'b1;
    run(14, "R6 trigger held");
    trig = 1'b0;
    run(4, "R5 idle");
    ls_width = 12'h015; dead_hl = 12'd9;
    trig = 1'b1;
    step("R5 trigger");
    trig = 1'b0;
    run(5, "R5 odd length");
    duty_cmd = 12'h000; ton_min = 12'h000; dead_hl = 12'd0; ls_width = 12'd0;
    trig = 1'b1;
    step("R5 empty cycle");
    trig = 1'b0;
    run(4, "R5 empty cycle");
    mode_shot = 1'b0; duty_cmd = 12'h019; ton_min = 12'h010; dead_hl = 12'd4;
    period_clk = 8'd3;
    run(10, "R4 back to free");
    rst = 1'b1;
    run(2, "R1 reset again");
    rst = 1'b0;
    run(4, "R2 restart");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule